// File: doc/BRIEF.md
# Boot Security Policy Monitor

This block keeps the security mode of a device from power-on reset onward and decides when the device must go into a latched lockdown. The device always wakes up in the secure mode. The first image loaded after power-on reset fixes the mode for the rest of the session. If that image is not encrypted, the block drops to the non-secure mode and locks the decryption engine and the HMAC engine. If it is encrypted, the block captures the image's key-source code and checks every later encrypted load against it.

Alongside the load checks, five tamper sources feed one sticky lockdown latch. These are a non-secure boot while the secure-only fuse is blown, a debug request while the debug-disable fuse is blown, an SEU report while SEU tracking is on, disagreement between the two copies of the decryption-enable signal, and a software force-reset bit. On entry to lockdown the block issues single-cycle requests to clear on-chip RAM, to clear the caches and to reset the programmable logic. Only power-on reset leaves the non-secure mode or lockdown. The actual decryption, authentication and memory clearing happen in other blocks.

Top module: `boot_guard`

## Requirements
- R1: While `por` is high at a clock edge, after that edge `mode_ns`, `lockdown`, `dec_lock`, `hmac_lock`, `rsa_lock` and all three request pulses are 0, and the next load is treated as the first boot image.
- R2: If the first load after `por` has `load_enc`=0, `mode_ns` goes to 1 after that edge, and `dec_lock` and `hmac_lock` stay 1 until the next `por`. The `load_pl` flag of the first load is ignored.
- R3: `rsa_lock` is 1 only in lockdown. It stays 0 in the non-secure mode.
- R4: `mode_ns` never returns to 0 except through `por`. In the non-secure mode, a later load with `load_enc`=1 causes lockdown.
- R5: In the secure mode, the first later load with `load_pl`=1 (a logic bitstream) must have `load_enc`=1, otherwise lockdown follows. Logic loads after that one, and processor loads (`load_pl`=0), may be unencrypted without lockdown.
- R6: The 2-bit `load_key` of the first load is captured. In the secure mode, a later load with `load_enc`=1 and a different `load_key` causes lockdown. An equal key does not.
- R7: Each tamper source alone, held for one cycle, sets `lockdown` after the next edge. The sources are a first load with `load_enc`=0 while `fuse_sec_only`=1, any `dbg_req` bit while `fuse_dbg_off`=1, `seu_flag` while `seu_track_en`=1, `dec_en_a`≠`dec_en_b`, and `sw_force_rst`.
- R8: `lockdown` stays 1 until `por`. Loads strobed during lockdown change neither `mode_ns` nor the captured key.
- R9: `clr_ram`, `clr_cache` and `pl_reset` are high together for exactly one cycle: the first cycle in which `lockdown` reads 1. They are low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| load_stb | input | 1 | One image load completes this cycle |
| load_pl | input | 1 | 1 = logic bitstream, 0 = processor image |
| load_enc | input | 1 | Loaded image is encrypted |
| load_key | input | KEY_W | Key-source code of the load |
| fuse_sec_only | input | 1 | Secure-boot-only fuse |
| fuse_dbg_off | input | 1 | Debug-disable fuse |
| dbg_req | input | DBG_N | Debug chain / debug port enable requests |
| seu_track_en | input | 1 | SEU tracking enabled |
| seu_flag | input | 1 | SEU reported by the logic |
| dec_en_a | input | 1 | Decryption enable, copy A |
| dec_en_b | input | 1 | Decryption enable, copy B |
| sw_force_rst | input | 1 | Software force-reset control bit |
| mode_ns | output | 1 | 1 = non-secure mode |
| lockdown | output | 1 | Latched lockdown |
| dec_lock | output | 1 | Decryption engine disabled |
| hmac_lock | output | 1 | HMAC engine disabled |
| rsa_lock | output | 1 | RSA engine disabled |
| clr_ram | output | 1 | One-cycle request to clear on-chip RAM |
| clr_cache | output | 1 | One-cycle request to clear caches |
| pl_reset | output | 1 | One-cycle request to reset the logic |

## Verification
Directed sequences cover each path to lockdown one at a time. These are a key mismatch against an equal key, an unencrypted first bitstream against a later unencrypted one, an encrypted load after a non-secure boot, and each tamper source alone. A cause can therefore be told apart from its neighbours. Long random runs then mix loads with random flags and keys, rare tamper pulses and occasional power-on resets, and compare every output each cycle with a bench model. This exposes ordering faults: loads during lockdown, tamper in the same cycle as a load, and a second trigger that must not pulse the cleanup requests again.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
  typedef struct packed {
    logic ns;          // non-secure mode
    logic first_done;  // boot image seen
    logic pl_done;     // first logic bitstream seen
  } mode_t;
endpackage

// File: rtl/bg_mode_tracker.sv
module bg_mode_tracker
  import boot_guard_pkg::*;
#(
  parameter int KEY_W = 2
) (
  input  logic             clk,
  input  logic             por,
  input  logic             locked,
  input  logic             load_stb,
  input  logic             load_pl,
  input  logic             load_enc,
  input  logic [KEY_W-1:0] load_key,
  input  logic             fuse_sec_only,
  output mode_t            st,
  output logic             load_viol,
  output logic             boot_fuse_viol
);
  logic [KEY_W-1:0] key_q;
  logic             take;

  assign take = load_stb && !locked;

  always_comb begin
    load_viol      = 1'b0;
    boot_fuse_viol = 1'b0;
    if (take) begin
      if (!st.first_done)
        boot_fuse_viol = !load_enc && fuse_sec_only;
      else if (st.ns)
        load_viol = load_enc;
      else
        load_viol = (load_enc && (load_key != key_q)) ||
                    (load_pl && !st.pl_done && !load_enc);
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      st    <= '0;
      key_q <= '0;
    end else if (take) begin
      if (!st.first_done) begin
        st.first_done <= 1'b1;
        st.ns         <= !load_enc;
        key_q         <= load_key;
      end else if (load_pl) begin
        st.pl_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bg_tamper.sv
module bg_tamper #(
  parameter int DBG_N = 2
) (
  input  logic             fuse_dbg_off,
  input  logic [DBG_N-1:0] dbg_req,
  input  logic             seu_track_en,
  input  logic             seu_flag,
  input  logic             dec_en_a,
  input  logic             dec_en_b,
  input  logic             sw_force_rst,
  input  logic             boot_fuse_viol,
  input  logic             load_viol,
  output logic             trig
);
  localparam int NSRC = 6;
  logic [DBG_N-1:0] dbg_hit;
  logic [NSRC-1:0]  src;

  genvar g;
  generate
    for (g = 0; g < DBG_N; g++) begin : g_dbg
      assign dbg_hit[g] = fuse_dbg_off && dbg_req[g];
    end
  endgenerate

  assign src  = {load_viol, boot_fuse_viol, sw_force_rst,
                 dec_en_a ^ dec_en_b, seu_track_en && seu_flag, |dbg_hit};
  assign trig = |src;
endmodule

// File: rtl/bg_lock_ctrl.sv
module bg_lock_ctrl #(
  parameter int NREQ = 3
) (
  input  logic            clk,
  input  logic            por,
  input  logic            trig,
  output logic            locked,
  output logic [NREQ-1:0] req
);
  always_ff @(posedge clk) begin
    if (por) begin
      locked <= 1'b0;
    end else if (trig) begin
      locked <= 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREQ; g++) begin : g_req
      always_ff @(posedge clk) begin
        if (por) req[g] <= 1'b0;
        else     req[g] <= trig && !locked;
      end
    end
  endgenerate
endmodule

// File: rtl/boot_guard.sv
module boot_guard
  import boot_guard_pkg::*;
#(
  parameter int KEY_W = 2,
  parameter int DBG_N = 2
) (
  input  logic             clk,
  input  logic             por,
  input  logic             load_stb,
  input  logic             load_pl,
  input  logic             load_enc,
  input  logic [KEY_W-1:0] load_key,
  input  logic             fuse_sec_only,
  input  logic             fuse_dbg_off,
  input  logic [DBG_N-1:0] dbg_req,
  input  logic             seu_track_en,
  input  logic             seu_flag,
  input  logic             dec_en_a,
  input  logic             dec_en_b,
  input  logic             sw_force_rst,
  output logic             mode_ns,
  output logic             lockdown,
  output logic             dec_lock,
  output logic             hmac_lock,
  output logic             rsa_lock,
  output logic             clr_ram,
  output logic             clr_cache,
  output logic             pl_reset
);
  localparam int NREQ = 3;
  mode_t           st;
  logic            load_viol, boot_fuse_viol, trig, locked;
  logic [NREQ-1:0] req;

  bg_mode_tracker #(.KEY_W(KEY_W)) u_mode (
    .clk(clk), .por(por), .locked(locked), .load_stb(load_stb),
    .load_pl(load_pl), .load_enc(load_enc), .load_key(load_key),
    .fuse_sec_only(fuse_sec_only), .st(st), .load_viol(load_viol),
    .boot_fuse_viol(boot_fuse_viol)
  );

  bg_tamper #(.DBG_N(DBG_N)) u_tamper (
    .fuse_dbg_off(fuse_dbg_off), .dbg_req(dbg_req), .seu_track_en(seu_track_en),
    .seu_flag(seu_flag), .dec_en_a(dec_en_a), .dec_en_b(dec_en_b),
    .sw_force_rst(sw_force_rst), .boot_fuse_viol(boot_fuse_viol),
    .load_viol(load_viol), .trig(trig)
  );

  bg_lock_ctrl #(.NREQ(NREQ)) u_lock (
    .clk(clk), .por(por), .trig(trig), .locked(locked), .req(req)
  );

  assign mode_ns   = st.ns;
  assign lockdown  = locked;
  assign dec_lock  = st.ns | locked;
  assign hmac_lock = st.ns | locked;
  assign rsa_lock  = locked;
  assign clr_ram   = req[0];
  assign clr_cache = req[1];
  assign pl_reset  = req[2];
endmodule

// File: rtl/boot_guard_chk.sv
module boot_guard_chk (
  input logic clk,
  input logic por,
  input logic dec_en_a,
  input logic dec_en_b,
  input logic sw_force_rst,
  input logic mode_ns,
  input logic lockdown,
  input logic dec_lock,
  input logic hmac_lock,
  input logic rsa_lock,
  input logic clr_ram,
  input logic clr_cache,
  input logic pl_reset
);
  AST_POR_CLEAR: assert property (@(posedge clk) por |=> !lockdown && !mode_ns && !clr_ram); // R1
  AST_NS_ENGINE_LOCK: assert property (@(posedge clk) disable iff (por) mode_ns |-> dec_lock && hmac_lock); // R2
  AST_RSA_OPEN: assert property (@(posedge clk) disable iff (por) !lockdown |-> !rsa_lock); // R3
  AST_NS_STICKY: assert property (@(posedge clk) disable iff (por) mode_ns |=> mode_ns); // R4
  AST_MISMATCH_LOCK: assert property (@(posedge clk) disable iff (por) (dec_en_a != dec_en_b) |=> lockdown); // R7
  AST_FORCE_LOCK: assert property (@(posedge clk) disable iff (por) sw_force_rst |=> lockdown); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (por) lockdown |=> lockdown); // R8
  AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (por) clr_ram |-> $rose(lockdown)); // R9
  AST_PULSE_TOGETHER: assert property (@(posedge clk) disable iff (por) clr_ram == clr_cache && clr_ram == pl_reset); // R9
endmodule

bind boot_guard boot_guard_chk u_chk (
  .clk(clk), .por(por), .dec_en_a(dec_en_a), .dec_en_b(dec_en_b),
  .sw_force_rst(sw_force_rst), .mode_ns(mode_ns), .lockdown(lockdown),
  .dec_lock(dec_lock), .hmac_lock(hmac_lock), .rsa_lock(rsa_lock),
  .clr_ram(clr_ram), .clr_cache(clr_cache), .pl_reset(pl_reset)
);

// File: tb/boot_guard_bench.sv
module boot_guard_bench;
  localparam int KEY_W = 2;
  localparam int DBG_N = 2;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic load_stb = 0, load_pl = 0, load_enc = 0;
  logic [KEY_W-1:0] load_key = '0;
  logic fuse_sec_only = 0, fuse_dbg_off = 0;
  logic [DBG_N-1:0] dbg_req = '0;
  logic seu_track_en = 0, seu_flag = 0, dec_en_a = 1, dec_en_b = 1, sw_force_rst = 0;
  logic mode_ns, lockdown, dec_lock, hmac_lock, rsa_lock, clr_ram, clr_cache, pl_reset;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  bit m_ns, m_lock, m_first, m_pl, m_pulse;
  logic [KEY_W-1:0] m_key;

  always #10 clk = ~clk;

  boot_guard #(.KEY_W(KEY_W), .DBG_N(DBG_N)) u_boot_guard (
    .clk(clk), .por(por), .load_stb(load_stb), .load_pl(load_pl), .load_enc(load_enc),
    .load_key(load_key), .fuse_sec_only(fuse_sec_only), .fuse_dbg_off(fuse_dbg_off),
    .dbg_req(dbg_req), .seu_track_en(seu_track_en), .seu_flag(seu_flag),
    .dec_en_a(dec_en_a), .dec_en_b(dec_en_b), .sw_force_rst(sw_force_rst),
    .mode_ns(mode_ns), .lockdown(lockdown), .dec_lock(dec_lock), .hmac_lock(hmac_lock),
    .rsa_lock(rsa_lock), .clr_ram(clr_ram), .clr_cache(clr_cache), .pl_reset(pl_reset)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit tamper_now();
    return (fuse_dbg_off && |dbg_req) || (seu_track_en && seu_flag) ||
           (dec_en_a != dec_en_b) || sw_force_rst;
  endfunction

  // advance model by one edge using the inputs now applied
  task automatic model_step();
    bit viol, trig;
    viol = 0;
    if (load_stb && !m_lock) begin
      if (!m_first)  viol = !load_enc && fuse_sec_only;
      else if (m_ns) viol = load_enc;
      else           viol = (load_enc && load_key != m_key) || (load_pl && !m_pl && !load_enc);
    end
    trig = viol || tamper_now();
    if (por) begin
      m_ns = 0; m_lock = 0; m_first = 0; m_pl = 0; m_pulse = 0; m_key = '0;
    end else begin
      if (load_stb && !m_lock) begin
        if (!m_first) begin m_first = 1; m_ns = !load_enc; m_key = load_key; end
        else if (load_pl) m_pl = 1;
      end
      m_pulse = trig && !m_lock;
      if (trig) m_lock = 1;
    end
  endtask

  // one clock: model, wait edge, check every output
  task automatic cyc(string tag);
    model_step();
    @(posedge clk); #2;
    chk({tag, " mode_ns"},   mode_ns,   m_ns);
    chk({tag, " lockdown"},  lockdown,  m_lock);
    chk({tag, " dec_lock"},  dec_lock,  m_ns | m_lock);
    chk({tag, " hmac_lock"}, hmac_lock, m_ns | m_lock);
    chk({tag, " rsa_lock"},  rsa_lock,  m_lock);
    chk({tag, " clr_ram"},   clr_ram,   m_pulse);
    chk({tag, " clr_cache"}, clr_cache, m_pulse);
    chk({tag, " pl_reset"},  pl_reset,  m_pulse);
  endtask

  task automatic idle();
    por = 0; load_stb = 0; load_pl = 0; load_enc = 0; load_key = '0;
    dbg_req = '0; seu_flag = 0; dec_en_a = 1; dec_en_b = 1; sw_force_rst = 0;
  endtask

  task automatic do_por(string tag);
    idle(); por = 1; cyc(tag); por = 0;
  endtask

  task automatic load(string tag, bit pl, bit enc, logic [KEY_W-1:0] key);
    load_stb = 1; load_pl = pl; load_enc = enc; load_key = key;
    cyc(tag); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    idle(); por = 1;
    cyc("R1 reset"); cyc("R1 reset");
    chk("R1 lockdown low", lockdown, 1'b0);
    chk("R1 secure", mode_ns, 1'b0);

    // secure boot, key 2
    do_por("R1");
    load("R6 first enc", 1, 1, 2'd2);         // pl flag ignored on first load
    chk("R2 pl flag ignored on first", mode_ns, 1'b0);
    load("R5 proc unenc ok", 0, 0, 2'd0);
    load("R5 first pl enc", 1, 1, 2'd2);
    load("R5 later pl unenc ok", 1, 0, 2'd1);
    chk("R5 no lockdown", lockdown, 1'b0);
    load("R6 same key ok", 0, 1, 2'd2);
    chk("R6 same key", lockdown, 1'b0);
    load("R6 key mismatch", 0, 1, 2'd1);
    chk("R6 lockdown", lockdown, 1'b1);
    chk("R9 pulse", clr_ram, 1'b1);
    cyc("R9 after");
    chk("R9 single", clr_ram, 1'b0);
    load("R8 load ignored", 0, 0, 2'd0);
    load("R8 load ignored", 0, 1, 2'd3);
    chk("R8 mode frozen", mode_ns, 1'b0);
    sw_force_rst = 1; cyc("R9 retrigger"); idle();
    repeat (3) cyc("R8 sticky");

    // non-secure boot
    do_por("R1 clears lockdown");
    chk("R1 cleared", lockdown, 1'b0);
    load("R2 first unenc", 0, 0, 2'd1);
    chk("R2 ns", mode_ns, 1'b1);
    chk("R2 dec lock", dec_lock, 1'b1);
    chk("R3 rsa open", rsa_lock, 1'b0);
    load("R4 unenc ok", 1, 0, 2'd1);
    repeat (3) cyc("R4 sticky");
    load("R4 enc after ns", 0, 1, 2'd1);
    chk("R4 lockdown", lockdown, 1'b1);
    chk("R3 rsa locked", rsa_lock, 1'b1);

    // first logic bitstream unencrypted in secure mode
    do_por("R1");
    load("R5 boot enc", 0, 1, 2'd0);
    load("R5 first pl unenc", 1, 0, 2'd0);
    chk("R5 lockdown", lockdown, 1'b1);

    // each tamper source alone
    do_por("R1"); fuse_sec_only = 1;
    load("R7 sec-only fuse", 0, 0, 2'd0);
    chk("R7 fuse lockdown", lockdown, 1'b1);
    fuse_sec_only = 0;
    do_por("R1"); fuse_dbg_off = 1; dbg_req = 2'b01; cyc("R7 dbg0"); idle();
    chk("R7 dbg lockdown", lockdown, 1'b1);
    do_por("R1"); dbg_req = 2'b10; cyc("R7 dbg1 fuse on"); idle();
    fuse_dbg_off = 0;
    do_por("R1"); dbg_req = 2'b11; cyc("R7 dbg no fuse"); idle();
    chk("R7 dbg no fuse", lockdown, 1'b0);
    seu_flag = 1; cyc("R7 seu untracked"); idle();
    chk("R7 seu untracked", lockdown, 1'b0);
    seu_track_en = 1; seu_flag = 1; cyc("R7 seu"); idle(); seu_track_en = 0;
    chk("R7 seu lockdown", lockdown, 1'b1);
    do_por("R1"); dec_en_b = 0; cyc("R7 mismatch"); idle();
    chk("R7 mismatch lockdown", lockdown, 1'b1);
    do_por("R1"); sw_force_rst = 1; cyc("R7 force"); idle();
    chk("R7 force lockdown", lockdown, 1'b1);

    // constrained random
    do_por("R1");
    for (int i = 0; i < 6000; i++) begin
      idle();
      por          = ($urandom % 150) == 0;
      load_stb     = ($urandom % 3) == 0;
      load_pl      = $urandom % 2;
      load_enc     = ($urandom % 4) != 0;
      load_key     = (($urandom % 4) == 0) ? KEY_W'($urandom) : 2'd1;
      fuse_sec_only = ($urandom % 8) == 0;
      fuse_dbg_off = $urandom % 2;
      dbg_req      = (($urandom % 80) == 0) ? DBG_N'($urandom) : '0;
      seu_track_en = $urandom % 2;
      seu_flag     = ($urandom % 80) == 0;
      dec_en_b     = ($urandom % 120) != 0;
      sw_force_rst = ($urandom % 150) == 0;
      cyc("R4 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule